// File: doc/BRIEF.md
# Nickel-and-Dime Vending Controller

This block is a small synchronous Mealy machine that collects coins toward one item priced at 15 cents. It accepts two coin values, a nickel worth 5 cents and a dime worth 10 cents, and remembers the credit collected so far: 0, 5 or 10 cents. When a coin brings the credit to 15 cents or beyond, the block raises a vend strobe in that same cycle. When the total reaches 20 cents, it also raises a strobe that returns one nickel. The credit then clears to zero.

A coin detector upstream presents a two-bit code once per clock, and the code is sampled on the rising edge. Both strobes are combinational functions of the stored credit and the present code. The consumer must therefore sample them at the clock edge that accepts the coin. The stored credit is updated at that same edge.

Top module: `vend_ctrl`

## Requirements
- R1: The coin code is decoded as follows: 2'b00 means no coin, 2'b01 is a nickel, 2'b10 is a dime, and 2'b11 is treated exactly like no coin.
- R2: A low `rst_n` sampled at a rising edge clears the credit to zero. While `rst_n` is low, `vend` and `change` stay low.
- R3: At zero credit, a nickel moves the credit to 5 cents and a dime moves it to 10 cents. Neither strobe is raised.
- R4: At 5 cents, a nickel moves the credit to 10 cents with no strobe. A dime raises `vend` without `change` and clears the credit.
- R5: At 10 cents, a nickel raises `vend` without `change` and clears the credit. A dime raises both `vend` and `change` and clears the credit.
- R6: When no coin is presented, the credit is held and both strobes stay low.
- R7: The strobes appear in the same cycle as the completing coin and last one cycle only. Any following cycle without a coin shows them low.
- R8: `change` is never high unless `vend` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| coin | input | 2 | Coin code sampled each edge (see R1) |
| vend | output | 1 | Dispense strobe for the current cycle |
| change | output | 1 | Return-one-nickel strobe for the current cycle |

## Verification
The credit register is internal, so a wrong stored credit only shows at the ports when a later coin arrives. For example, if the credit is wrongly cleared, a later coin that should complete the price produces no `vend`. If the credit is wrongly advanced, `vend` fires early, or `change` appears after a nickel. The longest hidden interval is two coins, so every sequence of up to four coins starting from reset is applied and checked against a credit model. Long random streams with idle and illegal codes mixed in show whether a corruption during idle cycles surfaces at the next coin.

// File: rtl/vend_pkg.sv
// Package: shared types for the vending controller.
// Assumes: credit never exceeds 10 cents between coins.
package vend_pkg;
    localparam int COIN_W  = 2;
    localparam int STATE_W = 2;

    typedef enum logic [COIN_W-1:0] {
        COIN_NONE   = 2'b00,
        COIN_NICKEL = 2'b01,
        COIN_DIME   = 2'b10,
        COIN_BAD    = 2'b11
    } coin_t;

    typedef enum logic [STATE_W-1:0] {
        CR_0     = 2'b00,
        CR_5     = 2'b01,
        CR_10    = 2'b10,
        CR_SPARE = 2'b11
    } credit_t;
endpackage

// File: rtl/vend_coin_decode.sv
// Module: turns the raw coin code into one-hot nickel/dime flags.
// Assumes: code 11 is an invalid reading and counts as no coin.
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic [COIN_W-1:0] coin_code,
    output logic              is_nickel,
    output logic              is_dime
);
    // Decode purpose: flag each legal coin value, drop everything else.
    always_comb begin
        is_nickel = (coin_code == COIN_NICKEL);
        is_dime   = (coin_code == COIN_DIME);
    end
endmodule

// File: rtl/vend_credit_logic.sv
// Module: next-credit and Mealy output logic.
// Assumes: at most one coin per cycle; spare encoding is treated as zero credit.
module vend_credit_logic
    import vend_pkg::*;
(
    input  credit_t cur,
    input  logic    is_nickel,
    input  logic    is_dime,
    output credit_t nxt,
    output logic    vend_o,
    output logic    change_o
);
    // Transition purpose: add the coin to the credit, dispense at 15 or more.
    always_comb begin
        nxt      = cur;
        vend_o   = 1'b0;
        change_o = 1'b0;
        unique case (cur)
            CR_0: begin
                if (is_nickel)      nxt = CR_5;
                else if (is_dime)   nxt = CR_10;
            end
            CR_5: begin
                if (is_nickel) nxt = CR_10;
                else if (is_dime) begin
                    nxt    = CR_0;
                    vend_o = 1'b1;
                end
            end
            CR_10: begin
                if (is_nickel) begin
                    nxt    = CR_0;
                    vend_o = 1'b1;
                end else if (is_dime) begin
                    nxt      = CR_0;
                    vend_o   = 1'b1;
                    change_o = 1'b1;
                end
            end
            default: nxt = CR_0;
        endcase
    end
endmodule

// File: rtl/vend_state_reg.sv
// Module: credit register with synchronous active-low reset.
// Assumes: rst_n is synchronous to clk.
module vend_state_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  credit_t d,
    output credit_t q
);
    // Register purpose: hold the credit, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= CR_0;
        else        q <= d;
    end
endmodule

// File: rtl/vend_ctrl.sv
// Module: top of the 15-cent vending controller (Mealy).
// Assumes: coin code is stable around the rising edge; strobes are
// combinational and valid to sample at that edge.
module vend_ctrl
    import vend_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COIN_W-1:0] coin,
    output logic              vend,
    output logic              change
);
    logic    nickel_f, dime_f;
    logic    vend_raw, change_raw;
    credit_t credit_q, credit_d;

    vend_coin_decode u_dec (
        .coin_code (coin),
        .is_nickel (nickel_f),
        .is_dime   (dime_f)
    );

    vend_credit_logic u_logic (
        .cur      (credit_q),
        .is_nickel(nickel_f),
        .is_dime  (dime_f),
        .nxt      (credit_d),
        .vend_o   (vend_raw),
        .change_o (change_raw)
    );

    vend_state_reg u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (credit_d),
        .q    (credit_q)
    );

    // Output purpose: silence the strobes while reset is held.
    always_comb begin
        vend   = vend_raw   & rst_n;
        change = change_raw & rst_n;
    end
endmodule

// File: rtl/vend_ctrl_chk.sv
// Checker: temporal properties of vend_ctrl, bound to every instance.
module vend_ctrl_chk
    import vend_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [COIN_W-1:0] coin,
    input logic              vend,
    input logic              change,
    input logic [STATE_W-1:0] credit
);
    logic idle;
    assign idle = (coin == COIN_NONE) || (coin == COIN_BAD);

    p_reset_clears_r2: assert property (@(posedge clk)
        !rst_n |=> credit == CR_0);
    p_reset_quiet_r2: assert property (@(posedge clk)
        !rst_n |-> (!vend && !change));
    p_zero_no_vend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        credit == CR_0 |-> !vend);
    p_vend_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vend |=> credit == CR_0);
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!vend && !change));
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> $stable(credit));
    p_change_needs_vend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        change |-> vend);
    p_nickel_no_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
        coin == COIN_NICKEL |-> !change);
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .coin  (coin),
    .vend  (vend),
    .change(change),
    .credit(credit_q)
);

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] coin = 2'b00;
    logic       vend, change;

    int n_run = 0;
    int n_fail = 0;
    int model_credit = 0;
    bit done = 0;

    vend_ctrl u0 (.clk(clk), .rst_n(rst_n), .coin(coin), .vend(vend), .change(change));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Coin value in cents per R1.
    function automatic int coin_value(input logic [1:0] c);
        if (c == 2'b01) return 5;
        if (c == 2'b10) return 10;
        return 0;
    endfunction

    // Requirement owning the cycle, from the model state.
    function automatic string req_of(input logic [1:0] c, input int cr);
        if (c == 2'b11) return "R1";
        if (coin_value(c) == 0) return "R6";
        if (cr == 0) return "R3";
        if (cr == 5) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {vend,change} actual=%b expected=%b", req, got, exp);
        end
    endtask

    // One cycle: drive after negedge, compare strobes, then update model at edge.
    task automatic step(input logic [1:0] c);
        int total;
        logic [1:0] exp;
        @(negedge clk);
        coin = c;
        #1;
        total = model_credit + coin_value(c);
        exp = {total >= 15, total >= 20};
        check(req_of(c, model_credit), {vend, change}, exp);
        if (!change || vend) ; else check("R8", {vend, change}, 2'b10);
        @(posedge clk);
        model_credit = (total >= 15) ? 0 : total;
    endtask

    task automatic do_reset(input logic [1:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        coin = c;
        #1;
        check("R2", {vend, change}, 2'b00);
        @(posedge clk);
        model_credit = 0;
        @(negedge clk);
        rst_n = 1'b1;
        coin = 2'b00;
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset(2'b00);
        // R2: reset state shows as zero credit; a nickel must not vend.
        step(2'b01); step(2'b10);
        // R2: reset with dime present at 10 cents clears credit and is quiet.
        step(2'b10);
        do_reset(2'b10);
        step(2'b10); step(2'b01);
        // R7: pulse lasts one cycle, then idle is quiet.
        step(2'b10); step(2'b10); step(2'b00); step(2'b00);
        // R1/R6: illegal code holds credit.
        step(2'b01); step(2'b11); step(2'b11); step(2'b10);
        // Exhaustive sequences of 1..4 coins from reset (R3, R4, R5).
        for (int len = 1; len <= 4; len++) begin
            for (int pat = 0; pat < (1 << len); pat++) begin
                do_reset(2'b00);
                for (int k = 0; k < len; k++)
                    step(pat[k] ? 2'b10 : 2'b01);
                step(2'b00);
            end
        end
        // Random stream, occasional reset.
        do_reset(2'b00);
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 200) == 0) do_reset(2'($urandom));
            else step(2'($urandom));
        end
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule